// File: doc/BRIEF.md
# Reshapable Two-Clock Block RAM

This block holds a fixed array of 1,152 bits, kept as 64 physical rows of 18 bits. A 2-bit shape input sets how the array looks from outside: a few wide words or many narrow ones. Writes come in on one clock and reads go out on a second, independent clock. Each port has a 9-bit address and an 18-bit data bus. The block works out the row and the bit lane for every access, so the surrounding logic only sees a flat address space with the selected word width.

The read port has two modes. In the registered mode, a read-clock edge with the read enable high loads an output register. In the transparent mode, the output follows the address, the stored contents and the shape without any clock. Because the shape only changes how addresses map onto the same physical bits, data written under one shape can be read back under another in a defined way.

Top module: `cfg_dpram`

## Requirements
- R1: `shape_i` selects the geometry: 0 gives 64 words of 18 bits, 1 gives 128×9, 2 gives 256×4 and 3 gives 512×2. Every address inside the selected depth reaches its own word.
- R2: Address bits above log2(depth) of the current shape are ignored on both ports.
- R3: For an address `a` under shape `m`, the word width is w = 18>>m. The physical row is `a[5:0]`. The lane is `a[8:6]` masked to its low m bits. The word occupies row bits lane*w up to lane*w+w-1. Only the low w bits of the write data are stored, so data written under one shape reads back under another through this mapping.
- R4: Read data is right-justified, and every bit at or above w is zero.
- R5: A write takes effect on a rising edge of `wclk_i` only when `wr_en_i` is high. With `wr_en_i` low, nothing stored changes.
- R6: In registered mode (`rd_async_i` = 0), a rising edge of `rclk_i` with `rd_en_i` high loads the word at `raddr_i` into the output.
- R7: In registered mode, a read-clock edge with `rd_en_i` low leaves `rdata_o` unchanged.
- R8: With `rd_async_i` = 1, `rdata_o` follows `raddr_i` and `shape_i` combinationally, with no read-clock edge needed.
- R9: A written word is visible to a read of the same address once the write edge has passed. In transparent mode it is visible at once. In registered mode it appears at the next read edge. A registered read on an edge shared with the write returns the contents from before the write.
- R10: While `rst_ni` is low, the output register is cleared, so `rdata_o` is 0 in registered mode. The stored array is not cleared.
- R11: The two clocks may run at unrelated periods without changing any of the above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of the read register |
| shape_i | input | 2 | Geometry select |
| rd_async_i | input | 1 | 1 = transparent read, 0 = registered read |
| wclk_i | input | 1 | Write clock |
| wr_en_i | input | 1 | Write enable |
| waddr_i | input | 9 | Write address |
| wdata_i | input | 18 | Write data, low w bits used |
| rclk_i | input | 1 | Read clock |
| rd_en_i | input | 1 | Registered-read load enable |
| raddr_i | input | 9 | Read address |
| rdata_o | output | 18 | Read data, right-justified |

## Verification
Each shape is filled completely with pseudo-random words that carry junk in the high data bits. The addresses carry junk in the bits above the depth, so a fault in lane selection, masking or address truncation shows up as a miscompare. Each filled shape is read back through the registered path and the transparent path. It is then read again under the next shape, which separates a correct lane layout from one that only round-trips inside a single shape. Separate directed patterns cover four cases: a disabled write, a held output with a moving address, a same-address write seen in both read modes and on a shared edge, and reset retaining the array. A final run with unrelated clock periods repeats the write/read pairs.

// File: rtl/cfg_ram_pkg.sv
package cfg_ram_pkg;
  localparam int unsigned DATA_W  = 18;
  localparam int unsigned ADDR_W  = 9;
  localparam int unsigned ROW_AW  = 6;
  localparam int unsigned ROWS    = 1 << ROW_AW;
  localparam int unsigned SHIFT_W = $clog2(DATA_W) + 1;

  typedef enum logic [1:0] {
    SHAPE_X18 = 2'd0,
    SHAPE_X9  = 2'd1,
    SHAPE_X4  = 2'd2,
    SHAPE_X2  = 2'd3
  } shape_e;

  typedef struct packed {
    logic [ROW_AW-1:0]  row;
    logic [SHIFT_W-1:0] shift;
    logic [DATA_W-1:0]  mask;
  } slot_t;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] m);
    lane_mask = DATA_W'((64'd1 << (DATA_W >> m)) - 64'd1);
  endfunction

  function automatic slot_t slot_of(input logic [1:0] m, input logic [ADDR_W-1:0] a);
    int unsigned w;
    int unsigned lane;
    slot_t s;
    w    = DATA_W >> m;
    lane = 32'(a[ADDR_W-1:ROW_AW]) & ((32'd1 << m) - 32'd1);
    s.row   = a[ROW_AW-1:0];
    s.shift = SHIFT_W'(lane * w);
    s.mask  = DATA_W'(64'(lane_mask(m)) << (lane * w));
    slot_of = s;
  endfunction
endpackage

// File: rtl/cfg_ram_slot.sv
module cfg_ram_slot
  import cfg_ram_pkg::*;
(
  input  logic [1:0]        shape_i,
  input  logic [ADDR_W-1:0] addr_i,
  output slot_t             slot_o
);
  always_comb slot_o = slot_of(shape_i, addr_i);
endmodule

// File: rtl/cfg_ram_array.sv
module cfg_ram_array
  import cfg_ram_pkg::*;
(
  input  logic              wclk_i,
  input  logic              wr_en_i,
  input  slot_t             wslot_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ROW_AW-1:0] rrow_i,
  output logic [DATA_W-1:0] rword_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  // read-modify-write of one lane; other lanes of the row untouched
  always_ff @(posedge wclk_i) begin
    if (wr_en_i)
      mem_q[wslot_i.row] <= (mem_q[wslot_i.row] & ~wslot_i.mask)
                          | ((wdata_i << wslot_i.shift) & wslot_i.mask);
  end

  assign rword_o = mem_q[rrow_i];
endmodule

// File: rtl/cfg_ram_rdport.sv
module cfg_ram_rdport
  import cfg_ram_pkg::*;
(
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              rd_async_i,
  input  slot_t             rslot_i,
  input  logic [DATA_W-1:0] rword_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] lane_data;
  logic [DATA_W-1:0] rd_q;

  assign lane_data = (rword_i & rslot_i.mask) >> rslot_i.shift;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= lane_data;
  end

  assign rdata_o = rd_async_i ? lane_data : rd_q;
endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram
  import cfg_ram_pkg::*;
(
  input  logic              rst_ni,
  input  logic [1:0]        shape_i,
  input  logic              rd_async_i,
  input  logic              wclk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  slot_t             wslot, rslot;
  logic [DATA_W-1:0] rword;

  cfg_ram_slot u_wslot (.shape_i(shape_i), .addr_i(waddr_i), .slot_o(wslot));
  cfg_ram_slot u_rslot (.shape_i(shape_i), .addr_i(raddr_i), .slot_o(rslot));

  cfg_ram_array u_array (
    .wclk_i (wclk_i),
    .wr_en_i(wr_en_i),
    .wslot_i(wslot),
    .wdata_i(wdata_i),
    .rrow_i (rslot.row),
    .rword_o(rword)
  );

  cfg_ram_rdport u_rdport (
    .rclk_i    (rclk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_async_i(rd_async_i),
    .rslot_i   (rslot),
    .rword_i   (rword),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/cfg_ram_chk.sv
module cfg_ram_chk
  import cfg_ram_pkg::*;
(
  input logic              rst_ni,
  input logic [1:0]        shape_i,
  input logic              rd_async_i,
  input logic              wclk_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rclk_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] raddr_i,
  input logic [DATA_W-1:0] rdata_o
);
  assert_reset_clear_R10: assert property (@(posedge rclk_i)
    (!rst_ni && !rd_async_i) |-> rdata_o == '0);

  assert_right_justified_R4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    rd_async_i |-> (rdata_o & ~lane_mask(shape_i)) == '0);

  assert_hold_no_enable_R7: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_en_i && !rd_async_i) |=> (rd_async_i || $stable(rdata_o)));

  assert_write_visible_R9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ($past(wr_en_i && waddr_i == raddr_i) && $stable(raddr_i) && $stable(shape_i) && rd_async_i)
      |-> rdata_o == ($past(wdata_i) & lane_mask(shape_i)));
endmodule

bind cfg_dpram cfg_ram_chk u_chk (
  .rst_ni    (rst_ni),
  .shape_i   (shape_i),
  .rd_async_i(rd_async_i),
  .wclk_i    (wclk_i),
  .wr_en_i   (wr_en_i),
  .waddr_i   (waddr_i),
  .wdata_i   (wdata_i),
  .rclk_i    (rclk_i),
  .rd_en_i   (rd_en_i),
  .raddr_i   (raddr_i),
  .rdata_o   (rdata_o)
);

// File: tb/cfg_dpram_test.sv
module cfg_dpram_test;
  logic        clk = 1'b0;
  logic        clk_r = 1'b0;
  logic        split = 1'b0;
  logic        rst_n = 1'b1;
  logic [1:0]  shape = 2'd0;
  logic        rd_async = 1'b0;
  logic        wr_en = 1'b0;
  logic [8:0]  waddr = '0;
  logic [17:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [8:0]  raddr = '0;
  logic [17:0] rdata;
  logic        wclk, rclk;

  int vectors = 0;
  int miscompares = 0;
  int cur_mode = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [17:0] ref_row [64];

  always #5 clk = ~clk;
  always #7 clk_r = ~clk_r;
  assign wclk = clk;
  assign rclk = split ? clk_r : clk;

  cfg_dpram uut (
    .rst_ni(rst_n), .shape_i(shape), .rd_async_i(rd_async),
    .wclk_i(wclk), .wr_en_i(wr_en), .waddr_i(waddr), .wdata_i(wdata),
    .rclk_i(rclk), .rd_en_i(rd_en), .raddr_i(raddr), .rdata_o(rdata)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic void ref_wr(int m, int a, logic [17:0] d);
    int w = 18 >> m;
    int row = a % 64;
    int lane = (a / 64) % (1 << m);
    for (int b = 0; b < w; b++) ref_row[row][lane*w + b] = d[b];
  endfunction

  function automatic logic [17:0] ref_rd(int m, int a);
    logic [17:0] r = '0;
    int w = 18 >> m;
    int row = a % 64;
    int lane = (a / 64) % (1 << m);
    for (int b = 0; b < w; b++) r[b] = ref_row[row][lane*w + b];
    return r;
  endfunction

  task automatic check(input logic [17:0] act, input logic [17:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // caller stands at a negedge of clk; returns at the next one
  task automatic wr(input int a, input logic [17:0] d);
    wr_en = 1'b1; waddr = a[8:0]; wdata = d;
    @(negedge clk);
    ref_wr(cur_mode, a, d);
    wr_en = 1'b0;
  endtask

  task automatic rd_sync(input int a, input string tag);
    @(negedge rclk);
    raddr = a[8:0]; rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    check(rdata, ref_rd(cur_mode, a), tag);
  endtask

  task automatic rd_async_chk(input int a, input string tag);
    raddr = a[8:0];
    #1;
    check(rdata, ref_rd(cur_mode, a), tag);
  endtask

  task automatic set_mode(input int m);
    cur_mode = m;
    shape = m[1:0];
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    #2 rst_n = 1'b0;
    #30;
    check(rdata, 18'h0, "R10 output cleared in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(rdata, 18'h0, "R10 output zero after reset");

    // full sweeps per shape
    for (int m = 0; m < 4; m++) begin
      int depth = 64 << m;
      set_mode(m);
      @(negedge clk);
      for (int a = 0; a < depth; a++) begin
        int aj = (a | (int'(rnd()) << (6 + m))) & 511;
        wr(aj, rnd()[17:0]);
      end
      for (int a = 0; a < depth; a++) begin
        int aj = (a | (int'(rnd()) << (6 + m))) & 511;
        rd_sync(aj, $sformatf("R1 R2 R3 R4 R6 registered read mode %0d addr %0d", m, a));
      end
      rd_async = 1'b1;
      for (int a = 0; a < depth; a++)
        rd_async_chk(a, $sformatf("R8 R4 transparent read mode %0d addr %0d", m, a));
      set_mode((m + 1) % 4);
      for (int a = 0; a < (64 << ((m + 1) % 4)); a++)
        rd_async_chk(a, $sformatf("R3 cross-shape read %0d->%0d addr %0d", m, (m + 1) % 4, a));
      set_mode(m);
      rd_async = 1'b0;
    end

    // R5: disabled write leaves contents alone
    set_mode(1);
    @(negedge clk);
    wr_en = 1'b0; waddr = 9'd5; wdata = ~ref_rd(1, 5);
    repeat (3) @(negedge clk);
    rd_sync(5, "R5 write enable low");

    // R7: hold with enable low while address moves
    rd_sync(7, "R7 load before hold");
    @(negedge clk);
    raddr = 9'd70; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    check(rdata, ref_rd(1, 7), "R7 output held");

    // R9: transparent, same address
    rd_async = 1'b1;
    raddr = 9'd10;
    @(negedge clk);
    begin
      logic [17:0] old_v = ref_rd(1, 10);
      logic [17:0] nd = ~{9'h0, old_v[8:0]} ^ 18'h2A5A5;
      wr_en = 1'b1; waddr = 9'd10; wdata = nd;
      #1 check(rdata, old_v, "R9 transparent before write edge");
      @(negedge clk);
      ref_wr(1, 10, nd);
      wr_en = 1'b0;
      check(rdata, {9'h0, nd[8:0]}, "R9 transparent after write edge");
    end
    rd_async = 1'b0;

    // R9: registered read on a shared edge sees old data, next edge new
    @(negedge clk);
    begin
      logic [17:0] old_v = ref_rd(1, 20);
      logic [17:0] nd = {9'h0, ~old_v[8:0]};
      wr_en = 1'b1; waddr = 9'd20; wdata = nd;
      rd_en = 1'b1; raddr = 9'd20;
      @(negedge clk);
      check(rdata, old_v, "R9 shared edge returns old data");
      ref_wr(1, 20, nd);
      wr_en = 1'b0;
      @(negedge clk);
      rd_en = 1'b0;
      check(rdata, nd, "R9 next read edge returns new data");
    end

    // R11: unrelated clock periods
    split = 1'b1;
    set_mode(2);
    for (int i = 0; i < 200; i++) begin
      int a = int'(rnd()) & 511;
      @(negedge clk);
      wr(a, rnd()[17:0]);
      rd_sync(a, $sformatf("R11 split clocks written addr %0d", a));
      rd_sync(int'(rnd()) & 511, "R11 split clocks other addr");
    end
    split = 1'b0;

    // R10: reset mid-run clears output, keeps array
    set_mode(0);
    rd_sync(33, "R10 load before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(rdata, 18'h0, "R10 output cleared mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    rd_sync(33, "R10 array kept across reset");

    finish_up();
  end
endmodule